// File: doc/BRIEF.md
# DMA Channel Address Register Pair

This block keeps the transfer address of a single DMA channel as two copies: a base copy that holds the programmed start point, and a working copy that moves as transfers complete. Software reaches the address through a narrow register port one byte at a time. An internal byte pointer picks the lane for each access. A separate strobe returns the pointer to the low byte, so that a 16-bit value can always be written or read low byte first.

When a transfer completes, the working copy steps up or down by one, and the channel's direction input sets which. When a terminal count arrives while auto-initialize is on, the working copy is reloaded from the base copy, so the channel can start the same buffer again. The address driven toward the bus is one bit wider than the register. On byte channels it is the working copy unchanged. On word channels it is the working copy moved up by one bit position.

Top module: `dma_addr_pair`

## Requirements
- R1: A register write puts the data byte into the lane of the base copy that the pointer selects, and into the same lane of the working copy.
- R2: The read data always shows the pointer-selected lane of the working copy, never the base copy.
- R3: A transfer-done pulse adds one to the working copy when the direction input is 0 and subtracts one when it is 1, wrapping modulo 2^16 (0xFFFF+1 = 0x0000, 0x0000-1 = 0xFFFF).
- R4: A terminal-count pulse with auto-initialize set copies the base copy into the working copy. When a transfer-done pulse arrives in the same cycle, the reload takes precedence.
- R5: A terminal-count pulse with auto-initialize clear leaves the working copy unchanged.
- R6: The byte pointer is 0 (low byte, bits 7:0) after reset and 1 (high byte, bits 15:8) after one access. Each cycle with a read, a write or both moves it to the next lane exactly once.
- R7: The pointer-clear strobe sets the pointer to the low byte for the next cycle. An access in the same cycle still uses the old pointer, and the clear overrides the advance.
- R8: A register write takes precedence over a transfer-done or reload in the same cycle. The written lane takes the new byte and the other lane of the working copy is held.
- R9: The bus address is {1'b0, working} when the word-mode input is 0 and {working, 1'b0} when it is 1, so working bit 15 lands in bus bit 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (clears the byte pointer only) |
| reg_wr | input | 1 | Register byte write |
| reg_rd | input | 1 | Register byte read |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte from the working copy |
| ptr_clr | input | 1 | Byte pointer clear strobe |
| xfer_done | input | 1 | One transfer completed |
| term_cnt | input | 1 | Terminal count reached |
| auto_init | input | 1 | Auto-initialize enable |
| dir_down | input | 1 | 0: increment, 1: decrement |
| word_mode | input | 1 | 1: word-wide channel, address shifted left |
| bus_addr | output | 17 | Address presented to the bus |

## Verification
The bench uses the default parameters: a 16-bit address in 8-bit lanes. That gives a two-state pointer whose low/high toggle can be walked completely, and a 17-bit bus address whose top bit is reached by shifting a value with bit 15 set. Both wrap points of the 16-bit step are small enough to drive directly. So are every same-cycle collision: write against step, write against reload, reload against step, and clear against access.

// File: rtl/dma_addr_pair.sv
module dma_addr_pair #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              ptr_clr,
  input  logic              xfer_done,
  input  logic              term_cnt,
  input  logic              auto_init,
  input  logic              dir_down,
  input  logic              word_mode,
  output logic [ADDR_W:0]   bus_addr
);

  localparam int LANES = ADDR_W / BYTE_W;
  localparam int PTR_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(LANES - 1);

  logic [ADDR_W-1:0] base_q, cur_q, cur_d, base_d;
  logic [PTR_W-1:0]  ptr_q;
  logic              access, reload;

  assign access = reg_wr | reg_rd;
  assign reload = term_cnt & auto_init;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (ptr_clr) ptr_q <= '0;
    else if (access)  ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_comb begin
    base_d = base_q;
    cur_d  = cur_q;
    if (reg_wr) begin
      base_d[ptr_q*BYTE_W +: BYTE_W] = reg_wdata;
      cur_d[ptr_q*BYTE_W +: BYTE_W]  = reg_wdata;
    end else if (reload) begin
      cur_d = base_q;
    end else if (xfer_done) begin
      cur_d = dir_down ? cur_q - 1'b1 : cur_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    base_q <= base_d;
    cur_q  <= cur_d;
  end

  assign reg_rdata = cur_q[ptr_q*BYTE_W +: BYTE_W];
  assign bus_addr  = word_mode ? {cur_q, 1'b0} : {1'b0, cur_q};

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    a_r1_write_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && ptr_q == PTR_W'(g)) |=>
        (cur_q[g*BYTE_W +: BYTE_W] == $past(reg_wdata) &&
         base_q[g*BYTE_W +: BYTE_W] == $past(reg_wdata)));
  end

  a_r6_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !ptr_clr) |=>
      ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1));

  a_r6_ptr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!access && !ptr_clr) |=> $stable(ptr_q));

  a_r7_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> ptr_q == '0);

  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !reg_wr) |=> cur_q == $past(base_q));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !reg_wr && !reload) |=>
      cur_q == ($past(dir_down) ? $past(cur_q) - 1'b1 : $past(cur_q) + 1'b1));

  a_r5_no_auto: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !reload && !xfer_done) |=> $stable(cur_q) && $stable(base_q));

  a_r9_word_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    word_mode |-> (bus_addr[0] == 1'b0 && bus_addr[ADDR_W:1] == cur_q));

endmodule

// File: tb/tb_dma_addr_pair.sv
`timescale 1ns/1ps
module tb_dma_addr_pair;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0, ptr_clr = 0, xfer_done = 0, term_cnt = 0;
  logic auto_init = 0, dir_down = 0, word_mode = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [16:0] bus_addr;
  int runs = 0, fails = 0;

  always #2 clk = ~clk;

  dma_addr_pair dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_byte(logic [7:0] d, bit clr = 0, bit step = 0, bit tc = 0);
    @(negedge clk);
    reg_wr = 1; reg_wdata = d; ptr_clr = clr; xfer_done = step; term_cnt = tc;
    @(negedge clk);
    reg_wr = 0; ptr_clr = 0; xfer_done = 0; term_cnt = 0;
  endtask

  task automatic clear_ptr();
    @(negedge clk); ptr_clr = 1;
    @(negedge clk); ptr_clr = 0;
  endtask

  task automatic wr16(logic [15:0] v);
    clear_ptr();
    wr_byte(v[7:0]);
    wr_byte(v[15:8]);
  endtask

  task automatic rd16(output logic [15:0] v);
    clear_ptr();
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); reg_rd = 1; #0.5;
      v[i*8 +: 8] = reg_rdata;
      @(negedge clk); reg_rd = 0;
    end
  endtask

  task automatic pulse(bit step, bit tc);
    @(negedge clk); xfer_done = step; term_cnt = tc;
    @(negedge clk); xfer_done = 0; term_cnt = 0;
  endtask

  task automatic t_reset();
    wr_byte(8'h5A);
    chk("R6 reset ptr low", bus_addr[7:0], 8'h5A);
  endtask

  task automatic t_write_read();
    logic [15:0] v;
    wr16(16'h1234);
    rd16(v);
    chk("R1 R2 readback", v, 16'h1234);
    chk("R9 byte bus", bus_addr, 17'h01234);
  endtask

  task automatic t_step();
    logic [15:0] v;
    dir_down = 0; pulse(1, 0); pulse(1, 0);
    chk("R3 inc", bus_addr, 17'h01236);
    wr16(16'hFFFF); pulse(1, 0);
    chk("R3 inc wrap", bus_addr, 17'h00000);
    dir_down = 1; pulse(1, 0);
    chk("R3 dec wrap", bus_addr, 17'h0FFFF);
    rd16(v);
    chk("R2 read current", v, 16'hFFFF);
    dir_down = 0;
  endtask

  task automatic t_reload();
    logic [15:0] v;
    auto_init = 1; dir_down = 1;
    wr16(16'h4000);
    pulse(1, 0); pulse(1, 0); pulse(1, 0);
    rd16(v);
    chk("R2 not base", v, 16'h3FFD);
    pulse(0, 1);
    chk("R4 reload", bus_addr, 17'h04000);
    pulse(1, 0); pulse(1, 1);
    chk("R4 reload beats step", bus_addr, 17'h04000);
    dir_down = 0; auto_init = 0;
  endtask

  task automatic t_noauto();
    wr16(16'h0100); pulse(1, 0);
    pulse(0, 1);
    chk("R5 tc no auto", bus_addr, 17'h00101);
  endtask

  task automatic t_ptr();
    wr16(16'h0000);
    clear_ptr();
    @(negedge clk); reg_wr = 1; reg_rd = 1; reg_wdata = 8'hAA;
    @(negedge clk); reg_wr = 0; reg_rd = 0;
    wr_byte(8'hBB);
    chk("R6 rd+wr single advance", bus_addr, 17'h0BBAA);
    wr_byte(8'hCC);
    chk("R6 wraps to low", bus_addr, 17'h0BBCC);
  endtask

  task automatic t_clear();
    clear_ptr();
    wr_byte(8'h01);
    wr_byte(8'h77, 1);
    wr_byte(8'h02);
    chk("R7 clear with access", bus_addr, 17'h07702);
  endtask

  task automatic t_write_wins();
    wr16(16'h1000);
    clear_ptr();
    auto_init = 1;
    wr_byte(8'h34, 0, 1, 1);
    chk("R8 write wins", bus_addr, 17'h01034);
    pulse(1, 0);
    pulse(0, 1);
    chk("R8 R1 base got byte", bus_addr, 17'h01034);
    auto_init = 0;
  endtask

  task automatic t_word();
    wr16(16'h8001);
    word_mode = 1; #0.5;
    chk("R9 word shift", bus_addr, 17'h10002);
    word_mode = 0; #0.5;
    chk("R9 byte again", bus_addr, 17'h08001);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_write_read();
    t_step();
    t_reload();
    t_noauto();
    t_ptr();
    t_clear();
    t_write_wins();
    t_word();
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule